// File: doc/BRIEF.md
# SPI-Mode Card Block Data Engine

This block runs the data phase of one single-block transfer with a memory card in SPI mode. It takes over after the card has accepted a read or write command. The card's bytes move through an external SPI shifter. The engine asks that shifter for one byte exchange at a time: it presents a byte to send, and it receives the byte that was clocked in when the shifter reports completion. On the host side, the data bytes stream through two valid/ready byte channels, one for each direction.

For a read, the engine hunts for the start token within a bounded number of polls. It then delivers the block to the host and drops the two checksum bytes. For a write, it sends the start token, the host's bytes and two zero checksum bytes. It then collects the card's data-response token and waits, within a bound, for the card to leave its busy state. Every transfer ends with a one-cycle `done` pulse. Alongside the pulse, a timeout flag or an error flag tells how it ended, and both stay readable until the next start. The block length and both poll bounds are parameters. The block length defaults to 512 bytes and the start-token hunt to 20000 polls.

Top module: `sdx_xfer_engine`

## Requirements
- R1: After reset the engine is idle (`active`=0). No exchange is requested, `xchg_tx` is 0xFF, and `done`, `timeout_flag`, `error_flag`, `rd_valid` and `wr_ready` are all 0.
- R2: On a read (`start` with `dir_write`=0), each received 0xFF is skipped and polling goes on. If the 0xFE start token arrives within HUNT_LIMIT polls, the data phase begins. If HUNT_LIMIT consecutive polls all return 0xFF, the transfer ends with `done` and `timeout_flag`=1. `timeout_flag` and `error_flag` are never set together.
- R3: On a read, if the first byte that is not 0xFF is anything other than 0xFE, the transfer ends at once with `error_flag`=1. No data byte reaches the host and no further exchange takes place.
- R4: After the start token, a read delivers exactly BLOCK_LEN received bytes in order on `rd_data`. It then performs exactly two more exchanges, whose bytes are discarded, and ends with `done` and both flags clear. Every byte the engine sends during a read is 0xFF.
- R5: A received data byte stays on `rd_data` with `rd_valid` held until `rd_ready` takes it. No exchange is requested while a byte is held, and `done` never coincides with an unconsumed byte.
- R6: A write (`start` with `dir_write`=1) sends this sequence: 0xFE, the BLOCK_LEN host bytes in the order accepted on `wr_valid`/`wr_ready`, 0x00, 0x00, then 0xFF. While `wr_valid` is low, no data exchange is requested. `xchg_tx` stays stable while a request is pending.
- R7: The byte received for the 0xFF that follows the checksum is kept on `resp_token` until the next write response. If its low four bits equal 0x5, the high bits are ignored and the busy phase follows. Any other low nibble ends the transfer with `error_flag`=1.
- R8: In the busy phase the engine sends 0xFF repeatedly. The first 0xFF it receives ends the transfer with both flags clear. If BUSY_LIMIT consecutive replies differ from 0xFF, the transfer ends with `timeout_flag`=1.
- R9: `start` is ignored while a transfer is active. It is accepted in the cycle `done` is high: that start clears both flags and begins the new transfer.
- R10: While idle, `xchg_tx` is 0xFF and no exchange is requested. `done` lasts exactly one cycle, and the flags keep their values after it until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only while idle) |
| dir_write | input | 1 | Direction sampled with start: 1 write, 0 read |
| active | output | 1 | A transfer is in progress |
| xchg_req | output | 1 | Byte exchange requested, held until xchg_done |
| xchg_tx | output | 8 | Byte for the shifter to send |
| xchg_done | input | 1 | Shifter finished the pending exchange |
| xchg_rx | input | 8 | Byte received by the shifter, valid with xchg_done |
| wr_data | input | 8 | Host write byte |
| wr_valid | input | 1 | Host write byte available |
| wr_ready | output | 1 | Engine takes wr_data this cycle |
| rd_data | output | 8 | Received data byte for the host |
| rd_valid | output | 1 | rd_data holds an unconsumed byte |
| rd_ready | input | 1 | Host takes rd_data this cycle |
| done | output | 1 | One-cycle end-of-transfer pulse |
| timeout_flag | output | 1 | Last transfer ended on a poll bound |
| error_flag | output | 1 | Last transfer ended on a bad token or bad response |
| resp_token | output | 8 | Last write data-response byte received |

## Verification
Two events can fall in the same cycle: the completion pulse of one transfer and the start of the next. The bench raises `start` in exactly the cycle where it sees `done` high after a read that failed on a bad token. It then judges that the new read began, meaning `active` is set and both flags are clear one cycle later, and that the new read completes with the right data. The bench also produces a second case: host back-pressure that lands just as a data byte arrives. For this it lowers `rd_ready` on a fixed cadence during a read. It checks that no exchange request ever overlaps a held byte and that every byte reaches the host in order.

// File: rtl/sdx_pkg.sv
// Shared types and byte constants for the SPI-mode block data engine.
// Assumes card-side byte codes fixed by the card protocol in SPI mode.
package sdx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HUNT,    // read: polling for the start token
        ST_RDAT,    // read: data bytes
        ST_RCRC,    // read: two discarded checksum bytes
        ST_WTOK,    // write: sending start token
        ST_WDAT,    // write: data bytes
        ST_WCRC,    // write: two zero checksum bytes
        ST_WRSP,    // write: fetch data-response token
        ST_WBSY     // write: wait for busy release
    } sdx_state_t;

    localparam logic [7:0] BYTE_FILL  = 8'hFF;
    localparam logic [7:0] BYTE_START = 8'hFE;
    localparam logic [7:0] BYTE_ZERO  = 8'h00;
    localparam logic [3:0] NIB_ACCEPT = 4'h5;

endpackage

// File: rtl/sdx_step_counter.sv
// Clearable up-counter that flags the step which reaches LIMIT.
// Assumes LIMIT >= 2 and that the owner clears it before each use.
module sdx_step_counter #(
    parameter int LIMIT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    // Count steps since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (step)   cnt <= cnt + 1'b1;
    end

    // A step taken while this is high is the LIMIT-th one.
    assign last = (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/sdx_rx_hold.sv
// One-byte holding register between the card side and the host read channel.
// Assumes push only arrives while empty; the engine guarantees this.
module sdx_rx_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       pop_ready,
    output logic       full,
    output logic [7:0] data
);
    // Capture an incoming byte; release it on host acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= 8'h00;
        end else if (push) begin
            full <= 1'b1;
            data <= push_data;
        end else if (full && pop_ready) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/sdx_xfer_engine.sv
// Data-phase engine for one single-block card transfer in SPI mode.
// Requests one byte exchange at a time from an external shifter, hunts the
// read start token within HUNT_LIMIT polls, moves BLOCK_LEN bytes through
// host valid/ready channels, and on writes checks the response token and
// waits up to BUSY_LIMIT polls for busy release. Assumes the command phase
// has already completed and that xchg_done pulses once per request.
module sdx_xfer_engine
    import sdx_pkg::*;
#(
    parameter int BLOCK_LEN  = 512,
    parameter int HUNT_LIMIT = 20000,
    parameter int BUSY_LIMIT = 65535
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       dir_write,
    output logic       active,
    output logic       xchg_req,
    output logic [7:0] xchg_tx,
    input  logic       xchg_done,
    input  logic [7:0] xchg_rx,
    input  logic [7:0] wr_data,
    input  logic       wr_valid,
    output logic       wr_ready,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    input  logic       rd_ready,
    output logic       done,
    output logic       timeout_flag,
    output logic       error_flag,
    output logic [7:0] resp_token
);
    sdx_state_t state;
    logic       pend;
    logic [7:0] tx_q;
    logic       crc_second;
    logic       done_q, to_q, er_q;
    logic [7:0] resp_q;

    logic       start_acc, can_issue, issue, got, rx_fill;
    logic [7:0] next_tx;
    logic       byte_last, hunt_last, busy_last;

    assign start_acc = start && (state == ST_IDLE);
    assign got       = pend && xchg_done;
    assign issue     = !pend && can_issue;
    assign rx_fill   = (xchg_rx == BYTE_FILL);

    // Decide whether the current phase may start an exchange now.
    always_comb begin
        case (state)
            ST_IDLE:          can_issue = 1'b0;
            ST_RDAT, ST_RCRC: can_issue = !rd_valid;
            ST_WDAT:          can_issue = wr_valid;
            default:          can_issue = 1'b1;
        endcase
    end

    // Select the byte to send for the current phase.
    always_comb begin
        case (state)
            ST_WTOK: next_tx = BYTE_START;
            ST_WDAT: next_tx = wr_data;
            ST_WCRC: next_tx = BYTE_ZERO;
            default: next_tx = BYTE_FILL;
        endcase
    end

    sdx_step_counter #(.LIMIT(BLOCK_LEN)) u_byte_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_acc),
        .step(got && (state == ST_RDAT || state == ST_WDAT)),
        .last(byte_last)
    );

    sdx_step_counter #(.LIMIT(HUNT_LIMIT)) u_hunt_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_acc),
        .step(got && (state == ST_HUNT) && rx_fill),
        .last(hunt_last)
    );

    sdx_step_counter #(.LIMIT(BUSY_LIMIT)) u_busy_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_acc),
        .step(got && (state == ST_WBSY) && !rx_fill),
        .last(busy_last)
    );

    sdx_rx_hold u_hold (
        .clk(clk), .rst_n(rst_n),
        .push(got && (state == ST_RDAT)),
        .push_data(xchg_rx),
        .pop_ready(rd_ready),
        .full(rd_valid),
        .data(rd_data)
    );

    // Phase sequencing, exchange issue and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pend       <= 1'b0;
            tx_q       <= BYTE_FILL;
            crc_second <= 1'b0;
            done_q     <= 1'b0;
            to_q       <= 1'b0;
            er_q       <= 1'b0;
            resp_q     <= 8'h00;
        end else begin
            done_q <= 1'b0;
            if (start_acc) begin
                state      <= dir_write ? ST_WTOK : ST_HUNT;
                to_q       <= 1'b0;
                er_q       <= 1'b0;
                crc_second <= 1'b0;
            end else if (issue) begin
                pend <= 1'b1;
                tx_q <= next_tx;
            end else if (got) begin
                pend <= 1'b0;
                case (state)
                    ST_HUNT: begin
                        if (rx_fill) begin
                            if (hunt_last) begin
                                state <= ST_IDLE; done_q <= 1'b1;
                                to_q  <= 1'b1;    tx_q   <= BYTE_FILL;
                            end
                        end else if (xchg_rx == BYTE_START) begin
                            state <= ST_RDAT;
                        end else begin
                            state <= ST_IDLE; done_q <= 1'b1;
                            er_q  <= 1'b1;    tx_q   <= BYTE_FILL;
                        end
                    end
                    ST_RDAT: if (byte_last) state <= ST_RCRC;
                    ST_RCRC: begin
                        if (crc_second) begin
                            state <= ST_IDLE; done_q <= 1'b1; tx_q <= BYTE_FILL;
                        end else begin
                            crc_second <= 1'b1;
                        end
                    end
                    ST_WTOK: state <= ST_WDAT;
                    ST_WDAT: if (byte_last) state <= ST_WCRC;
                    ST_WCRC: begin
                        if (crc_second) state <= ST_WRSP;
                        else            crc_second <= 1'b1;
                    end
                    ST_WRSP: begin
                        resp_q <= xchg_rx;
                        if (xchg_rx[3:0] == NIB_ACCEPT) begin
                            state <= ST_WBSY;
                        end else begin
                            state <= ST_IDLE; done_q <= 1'b1;
                            er_q  <= 1'b1;    tx_q   <= BYTE_FILL;
                        end
                    end
                    ST_WBSY: begin
                        if (rx_fill) begin
                            state <= ST_IDLE; done_q <= 1'b1; tx_q <= BYTE_FILL;
                        end else if (busy_last) begin
                            state <= ST_IDLE; done_q <= 1'b1;
                            to_q  <= 1'b1;    tx_q   <= BYTE_FILL;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign active       = (state != ST_IDLE);
    assign xchg_req     = pend;
    assign xchg_tx      = tx_q;
    assign wr_ready     = (state == ST_WDAT) && !pend;
    assign done         = done_q;
    assign timeout_flag = to_q;
    assign error_flag   = er_q;
    assign resp_token   = resp_q;
endmodule

// File: rtl/sdx_xfer_chk.sv
// Property checker for sdx_xfer_engine, attached through bind.
// Assumes it sees the engine's ports only.
module sdx_xfer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       active,
    input logic       xchg_req,
    input logic [7:0] xchg_tx,
    input logic       xchg_done,
    input logic [7:0] rd_data,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic       done,
    input logic       timeout_flag,
    input logic       error_flag
);
    // R10
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (xchg_tx == 8'hFF && !xchg_req));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(timeout_flag && error_flag));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    // R5
    no_issue_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !xchg_req && !done);

    // R6
    tx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_req && !xchg_done |=> xchg_req && $stable(xchg_tx));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && start && !xchg_done |=> active);
endmodule

bind sdx_xfer_engine sdx_xfer_chk u_sdx_xfer_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .active(active),
    .xchg_req(xchg_req), .xchg_tx(xchg_tx), .xchg_done(xchg_done),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .done(done), .timeout_flag(timeout_flag), .error_flag(error_flag)
);

// File: tb/test_sdx_xfer_engine.sv
`timescale 1ns/1ps
// Directed bench for sdx_xfer_engine with a scripted shifter model.
module test_sdx_xfer_engine;
    localparam int BL = 8;
    localparam int HL = 20;
    localparam int BSL = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       dir_write = 1'b0;
    logic       active, xchg_req, wr_ready, rd_valid, done;
    logic       timeout_flag, error_flag;
    logic [7:0] xchg_tx, rd_data, resp_token;
    logic       xchg_done = 1'b0;
    logic [7:0] xchg_rx = 8'hFF;
    logic [7:0] wr_data = 8'h00;
    logic       wr_valid = 1'b0;
    logic       rd_ready = 1'b1;

    sdx_xfer_engine #(.BLOCK_LEN(BL), .HUNT_LIMIT(HL), .BUSY_LIMIT(BSL)) i_sdx_xfer_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
        .active(active), .xchg_req(xchg_req), .xchg_tx(xchg_tx),
        .xchg_done(xchg_done), .xchg_rx(xchg_rx), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .done(done),
        .timeout_flag(timeout_flag), .error_flag(error_flag),
        .resp_token(resp_token)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    logic [7:0] resp_mem [0:127];
    int         resp_len = 0;
    logic [7:0] dflt = 8'hFF;
    logic [7:0] tx_log [0:127];
    int         tx_n = 0;
    logic [7:0] rd_log [0:63];
    int         rd_n = 0;
    logic [7:0] wblk [0:BL-1];
    int         widx = 0;
    bit         rd_stall = 0, wr_stall = 0, wr_fire_prev = 0;
    int         cyc = 0;
    int         viol = 0;
    bit         d_to, d_er;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Shifter, host sink and host source models, all acting at falling edges.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (xchg_done) xchg_done = 1'b0;
            else if (xchg_req) begin
                if (tx_n < 128) tx_log[tx_n] = xchg_tx;
                xchg_rx = (tx_n < resp_len) ? resp_mem[tx_n] : dflt;
                tx_n++;
                xchg_done = 1'b1;
            end
            rd_ready = rd_stall ? (cyc % 3 == 0) : 1'b1;
            if (rd_valid && rd_ready) begin
                if (rd_n < 64) rd_log[rd_n] = rd_data;
                rd_n++;
            end
            if ((xchg_req && rd_valid) || (done && rd_valid)) viol++;
            if (wr_fire_prev) widx++;
            wr_valid = (widx < BL) && (!wr_stall || (cyc % 3 != 0));
            wr_data = wblk[widx % BL];
            wr_fire_prev = wr_valid && wr_ready;
        end
    end

    task automatic clear_logs();
        tx_n = 0; rd_n = 0; widx = 0; viol = 0; resp_len = 0; dflt = 8'hFF;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        chk("done seen", int'(done), 1);
        d_to = timeout_flag; d_er = error_flag;
    endtask

    task automatic run_xfer(bit dir);
        @(negedge clk); start = 1'b1; dir_write = dir;
        @(negedge clk); start = 1'b0;
        wait_done();
        repeat (6) @(negedge clk);
    endtask

    task automatic load_read_script(int ff_n, int base);
        for (int i = 0; i < ff_n; i++) resp_mem[base+i] = 8'hFF;
        resp_mem[base+ff_n] = 8'hFE;
        for (int i = 0; i < BL; i++) resp_mem[base+ff_n+1+i] = 8'h30 + 8'(i*7);
        resp_mem[base+ff_n+1+BL] = 8'hA1;
        resp_mem[base+ff_n+2+BL] = 8'hB2;
        resp_len = base + ff_n + 3 + BL;
    endtask

    task automatic check_read_data(string tag);
        chk({tag, " byte count"}, rd_n, BL);
        for (int i = 0; i < BL; i++)
            chk({tag, " byte value"}, int'(rd_log[i]), int'(8'h30 + 8'(i*7)));
    endtask

    task automatic check_all_fill(string tag, int n);
        int bad = 0;
        for (int i = 0; i < n; i++) if (tx_log[i] != 8'hFF) bad++;
        chk({tag, " non-FF sent"}, bad, 0);
    endtask

    task automatic t_reset();
        chk("R1 active", int'(active), 0);
        chk("R1 req", int'(xchg_req), 0);
        chk("R1 tx", int'(xchg_tx), 8'hFF);
        chk("R1 done", int'(done), 0);
        chk("R1 flags", int'({timeout_flag, error_flag}), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 wr_ready", int'(wr_ready), 0);
    endtask

    task automatic t_read_ok(bit stall);
        clear_logs(); rd_stall = stall;
        load_read_script(2, 0);
        run_xfer(1'b0);
        chk("R4 exchanges", tx_n, 13);
        check_all_fill("R4", 13);
        check_read_data(stall ? "R5 stalled read" : "R4 read");
        chk("R4 flags", int'({d_to, d_er}), 0);
        chk("R5 held-byte overlap", viol, 0);
        chk("R10 idle tx", int'(xchg_tx), 8'hFF);
        chk("R10 idle req", int'(xchg_req), 0);
        rd_stall = 0;
    endtask

    task automatic t_hunt_timeout();
        clear_logs();
        run_xfer(1'b0);
        chk("R2 timeout polls", tx_n, HL);
        chk("R2 timeout flag", int'(d_to), 1);
        chk("R2 error flag", int'(d_er), 0);
        chk("R2 no data", rd_n, 0);
    endtask

    task automatic t_hunt_edge();
        clear_logs();
        load_read_script(HL - 1, 0);
        run_xfer(1'b0);
        chk("R2 edge exchanges", tx_n, HL + BL + 2);
        chk("R2 edge flags", int'({d_to, d_er}), 0);
        check_read_data("R2 edge");
    endtask

    task automatic t_bad_token();
        clear_logs();
        resp_mem[0] = 8'hFF; resp_mem[1] = 8'hFC; resp_len = 2;
        run_xfer(1'b0);
        chk("R3 exchanges", tx_n, 2);
        chk("R3 error flag", int'(d_er), 1);
        chk("R3 timeout flag", int'(d_to), 0);
        chk("R3 no data", rd_n, 0);
        chk("R10 flag held", int'(error_flag), 1);
    endtask

    task automatic load_write_script(logic [7:0] tok, int busy_n, logic [7:0] fill);
        for (int i = 0; i < 11; i++) resp_mem[i] = 8'hFF;
        resp_mem[11] = tok;
        for (int i = 0; i < busy_n; i++) resp_mem[12+i] = 8'h00;
        resp_len = 12 + busy_n;
        dflt = fill;
        for (int i = 0; i < BL; i++) wblk[i] = 8'hC3 ^ 8'(i*13);
    endtask

    task automatic check_write_stream(string tag);
        chk({tag, " token"}, int'(tx_log[0]), 8'hFE);
        for (int i = 0; i < BL; i++)
            chk({tag, " data"}, int'(tx_log[1+i]), int'(wblk[i]));
        chk({tag, " crc hi"}, int'(tx_log[BL+1]), 0);
        chk({tag, " crc lo"}, int'(tx_log[BL+2]), 0);
        chk({tag, " resp poll"}, int'(tx_log[BL+3]), 8'hFF);
    endtask

    task automatic t_write_ok(bit stall, int busy_n);
        clear_logs(); wr_stall = stall;
        load_write_script(8'hE5, busy_n, 8'hFF);
        run_xfer(1'b1);
        check_write_stream(stall ? "R6 stalled write" : "R6 write");
        chk("R8 exchanges", tx_n, 12 + busy_n + 1);
        check_all_fill("R8 busy", 0);
        chk("R8 flags", int'({d_to, d_er}), 0);
        chk("R7 token", int'(resp_token), 8'hE5);
        wr_stall = 0;
    endtask

    task automatic t_write_reject();
        clear_logs();
        load_write_script(8'h0B, 0, 8'hFF);
        run_xfer(1'b1);
        chk("R7 reject exchanges", tx_n, 12);
        chk("R7 reject error", int'(d_er), 1);
        chk("R7 reject token", int'(resp_token), 8'h0B);
    endtask

    task automatic t_busy_timeout();
        clear_logs();
        load_write_script(8'hE5, 0, 8'h00);
        run_xfer(1'b1);
        chk("R8 timeout exchanges", tx_n, 12 + BSL);
        chk("R8 timeout flag", int'(d_to), 1);
        chk("R8 error flag", int'(d_er), 0);
    endtask

    task automatic t_start_ignored();
        clear_logs();
        load_read_script(2, 0);
        @(negedge clk); start = 1'b1; dir_write = 1'b0;
        @(negedge clk); start = 1'b0;
        repeat (7) @(negedge clk);
        start = 1'b1; dir_write = 1'b1;
        @(negedge clk); start = 1'b0; dir_write = 1'b0;
        wait_done();
        repeat (6) @(negedge clk);
        chk("R9 ignored exchanges", tx_n, 13);
        check_all_fill("R9 ignored", 13);
        check_read_data("R9 ignored");
    endtask

    task automatic t_start_on_done();
        clear_logs();
        resp_mem[0] = 8'hFF; resp_mem[1] = 8'hFC;
        load_read_script(0, 2);
        @(negedge clk); start = 1'b1; dir_write = 1'b0;
        @(negedge clk); start = 1'b0;
        wait_done();
        chk("R9 first error", int'(d_er), 1);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R9 restarted", int'(active), 1);
        chk("R9 flags cleared", int'({timeout_flag, error_flag}), 0);
        wait_done();
        repeat (6) @(negedge clk);
        chk("R9 second flags", int'({d_to, d_er}), 0);
        chk("R9 total exchanges", tx_n, 2 + 1 + BL + 2);
        check_read_data("R9 second");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_read_ok(1'b0);
        t_read_ok(1'b1);
        t_hunt_timeout();
        t_hunt_edge();
        t_bad_token();
        t_write_ok(1'b0, 3);
        t_write_ok(1'b1, BSL - 1);
        t_write_reject();
        t_busy_timeout();
        t_start_ignored();
        t_start_on_done();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule